// File: doc/BRIEF.md
# Two-Level Lookahead Binary Adder

This block adds two unsigned binary operands and an incoming carry, and returns the sum word and the outgoing carry, with no clock and no storage. Each bit first forms a propagate term (the XOR of the two operand bits) and a generate term (their AND). The bits are collected into groups of four. Inside a group, a lookahead unit derives the carry into every bit position directly from that group's terms and its carry-in, so no carry ripples from one bit to the next.

Each group also condenses its four bits into one group propagate and one group generate. A second lookahead unit of the same shape takes these group terms and the adder's carry-in, and derives the carry-in of every group and the final carry-out. That unit's own propagate and generate are brought out, so a wider adder can chain this block as one more lookahead level. The operand width is a parameter. It must be a multiple of four and may span up to four groups. The default is 16 bits, which is four groups under one second-level unit.

Top module: `cla_adder`

## Requirements
- R1: `sum_out` equals (`op_a` + `op_b` + `carry_in`) modulo 2^WIDTH, for every input combination.
- R2: `carry_out` equals bit WIDTH of the full sum `op_a` + `op_b` + `carry_in`.
- R3: With both operands all ones and `carry_in` = 1, `sum_out` is all ones and `carry_out` is 1. With both operands all ones and `carry_in` = 0, `sum_out` is all ones except bit 0, which is 0, and `carry_out` is 1.
- R4: `prop_out` is 1 exactly when `op_a` XOR `op_b` is all ones, meaning every bit would pass an incoming carry through.
- R5: `gen_out` is 1 exactly when `op_a` + `op_b` produces a carry out of bit WIDTH-1 with `carry_in` = 0, regardless of the value on `carry_in`.
- R6: When `prop_out` is 1, `carry_out` equals `carry_in` and `sum_out` equals NOT `carry_in` replicated across all bits.
- R7: A carry created in a lower 4-bit group reaches every higher group. For example, 0x0FFF + 0x0001 gives 0x1000, and 0x00FF + 0x0001 with `carry_in` = 1 gives 0x0101. The carry entering each group equals the carry leaving the group below it.
- R8: The outputs depend only on the present inputs. After any input change, every output has its new value before the next sampling point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Incoming carry into bit 0 |
| sum_out | output | WIDTH | Sum modulo 2^WIDTH |
| carry_out | output | 1 | Carry out of the top bit |
| prop_out | output | 1 | Whole-word propagate term |
| gen_out | output | 1 | Whole-word generate term |

## Verification
Two functions can act on the same input vector: a group's own carry generation, and the pass-through of a carry that arrives from the groups below. They overlap when a carry created low in the word must cross a group that is all propagate, and that group then hands the carry on to a group that generates again. The bench provokes this with directed operands that place runs of ones across group boundaries, with both operands all ones under each `carry_in` value, and with a long stream of pseudo-random vectors. On every cycle the bench compares `sum_out`, `carry_out`, `prop_out` and `gen_out` against a behavioural integer addition and against whole-word XOR and carry-with-zero-input references.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int GROUP_BITS = 4;
  localparam int MAX_GROUPS = 4;
endpackage

// File: rtl/cla_bit_pg.sv
module cla_bit_pg #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] p,
  output logic [WIDTH-1:0] g
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign p[i] = a[i] ^ b[i];
    assign g[i] = a[i] & b[i];
  end
endmodule

// File: rtl/cla_lookahead4.sv
module cla_lookahead4 (
  input  logic [3:0] p,
  input  logic [3:0] g,
  input  logic       cin,
  output logic [3:0] c,
  output logic       grp_p,
  output logic       grp_g,
  output logic       cout
);
  assign c[0] = cin;
  assign c[1] = g[0] | (p[0] & cin);
  assign c[2] = g[1] | (p[1] & g[0]) | (p[1] & p[0] & cin);
  assign c[3] = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0])
              | (p[2] & p[1] & p[0] & cin);
  assign grp_p = &p;
  assign grp_g = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1])
               | (p[3] & p[2] & p[1] & g[0]);
  assign cout = grp_g | (grp_p & cin);

  // The flattened carries must agree with the one-step recurrence.
  always_comb begin
    for (int i = 0; i < 3; i++) begin
      a_r7_carry_recurrence: assert (c[i+1] == (g[i] | (p[i] & c[i])))
        else $error("lookahead carry %0d disagrees with recurrence", i + 1);
    end
    a_r7_cout_recurrence: assert (cout == (g[3] | (p[3] & c[3])))
      else $error("lookahead carry-out disagrees with recurrence");
    if (grp_p) begin
      a_r6_pass_through: assert (cout == cin)
        else $error("propagating group did not pass its carry through");
    end
  end
endmodule

// File: rtl/cla_sum_xor.sv
module cla_sum_xor #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] p,
  input  logic [WIDTH-1:0] c,
  output logic [WIDTH-1:0] s
);
  assign s = p ^ c;
endmodule

// File: rtl/cla_adder.sv
module cla_adder
  import cla_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum_out,
  output logic             carry_out,
  output logic             prop_out,
  output logic             gen_out
);
  localparam int NG = WIDTH / GROUP_BITS;

  initial begin
    a_width_legal: assert ((WIDTH % GROUP_BITS == 0) && (NG >= 1) && (NG <= MAX_GROUPS))
      else $error("WIDTH must be a multiple of 4 covering 1 to 4 groups");
  end

  logic [WIDTH-1:0] bit_p, bit_g, bit_c;
  logic [NG-1:0]    grp_p, grp_g, grp_cout;
  logic [MAX_GROUPS-1:0] lvl2_p, lvl2_g, grp_cin;

  cla_bit_pg #(.WIDTH(WIDTH)) u_pg (
    .a(op_a), .b(op_b), .p(bit_p), .g(bit_g)
  );

  // Unused upper slots of the second level pass carries and create none.
  for (genvar k = 0; k < MAX_GROUPS; k++) begin : g_pad
    if (k < NG) begin : g_used
      assign lvl2_p[k] = grp_p[k];
      assign lvl2_g[k] = grp_g[k];
    end else begin : g_empty
      assign lvl2_p[k] = 1'b1;
      assign lvl2_g[k] = 1'b0;
    end
  end

  cla_lookahead4 u_level2 (
    .p(lvl2_p), .g(lvl2_g), .cin(carry_in),
    .c(grp_cin), .grp_p(prop_out), .grp_g(gen_out), .cout(carry_out)
  );

  for (genvar k = 0; k < NG; k++) begin : g_group
    cla_lookahead4 u_grp (
      .p(bit_p[GROUP_BITS*k +: GROUP_BITS]),
      .g(bit_g[GROUP_BITS*k +: GROUP_BITS]),
      .cin(grp_cin[k]),
      .c(bit_c[GROUP_BITS*k +: GROUP_BITS]),
      .grp_p(grp_p[k]),
      .grp_g(grp_g[k]),
      .cout(grp_cout[k])
    );
  end

  cla_sum_xor #(.WIDTH(WIDTH)) u_sum (
    .p(bit_p), .c(bit_c), .s(sum_out)
  );

  always_comb begin
    a_r1_r2_arith: assert ({carry_out, sum_out} ==
        ({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in}))
      else $error("adder result disagrees with integer sum");
    for (int k = 0; k < NG - 1; k++) begin
      a_r7_group_chain: assert (grp_cout[k] == grp_cin[k+1])
        else $error("group %0d carry-out differs from next group carry-in", k);
    end
    a_r2_top_chain: assert (grp_cout[NG-1] == carry_out)
      else $error("top group carry-out differs from adder carry-out");
  end
endmodule

// File: tb/cla_adder_test.sv
module cla_adder_test;
  localparam int W = 16;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [W-1:0] a, b, s;
  logic cin, cout, pp, gg;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string tag = "R1";

  cla_adder #(.WIDTH(W)) uut (
    .op_a(a), .op_b(b), .carry_in(cin),
    .sum_out(s), .carry_out(cout), .prop_out(pp), .gen_out(gg)
  );

  task automatic check_now(string req);
    logic [W:0] full;
    logic [W:0] nocin;
    logic exp_p;
    full  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    nocin = {1'b0, a} + {1'b0, b};
    exp_p = &(a ^ b);
    checks++;
    if (s !== full[W-1:0]) begin
      errors++;
      $display("FAIL %s R1 sum: got %h expected %h", req, s, full[W-1:0]);
    end
    if (cout !== full[W]) begin
      errors++;
      $display("FAIL %s R2 carry_out: got %b expected %b", req, cout, full[W]);
    end
    if (pp !== exp_p) begin
      errors++;
      $display("FAIL %s R4 prop_out: got %b expected %b", req, pp, exp_p);
    end
    if (gg !== nocin[W]) begin
      errors++;
      $display("FAIL %s R5 gen_out: got %b expected %b", req, gg, nocin[W]);
    end
    if (exp_p && ((cout !== cin) || (s !== {W{~cin}}))) begin
      errors++;
      $display("FAIL %s R6 pass-through: got %b/%h expected %b/%h",
               req, cout, s, cin, {W{~cin}});
    end
  endtask

  task automatic expect_exact(string req, logic [W-1:0] es, logic ec);
    checks++;
    if (s !== es || cout !== ec) begin
      errors++;
      $display("FAIL %s: got %h/%b expected %h/%b", req, s, cout, es, ec);
    end
  endtask

  // Apply one vector just after a rising edge; the bench compares at the falling edge (R8).
  task automatic apply(logic [W-1:0] va, logic [W-1:0] vb, logic vc, string req);
    @(posedge clk);
    #0.5;
    a = va; b = vb; cin = vc; tag = req;
    @(negedge clk);
    check_now(req);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    a = '0; b = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    expect_exact("reset-state R1", 16'h0000, 1'b0);
    check_now("reset-state R8");

    apply(16'hFFFF, 16'hFFFF, 1'b1, "R3 ones cin1");
    expect_exact("R3 ones cin1", 16'hFFFF, 1'b1);
    apply(16'hFFFF, 16'hFFFF, 1'b0, "R3 ones cin0");
    expect_exact("R3 ones cin0", 16'hFFFE, 1'b1);
    apply(16'h0FFF, 16'h0001, 1'b0, "R7 cross three groups");
    expect_exact("R7 cross three groups", 16'h1000, 1'b0);
    apply(16'h00FF, 16'h0001, 1'b1, "R7 cross one group");
    expect_exact("R7 cross one group", 16'h0101, 1'b0);
    apply(16'h000F, 16'hFFF0, 1'b1, "R6 full propagate cin1");
    expect_exact("R6 full propagate cin1", 16'h0000, 1'b1);
    apply(16'hAAAA, 16'h5555, 1'b0, "R6 full propagate cin0");
    expect_exact("R6 full propagate cin0", 16'hFFFF, 1'b0);
    apply(16'h8000, 16'h8000, 1'b0, "R5 top generate");
    apply(16'hFFFF, 16'h0000, 1'b1, "R5 carry from cin only");
    apply(16'h0F0F, 16'h00F1, 1'b0, "R7 generate then propagate");

    for (int i = 0; i < W; i++) begin
      apply(16'hFFFF >> i, 16'h0001 << i, 1'b0, "R7 walking boundary");
      apply(16'h0001 << i, 16'h0001 << i, 1'b1, "R2 single generate");
    end

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      apply(r[15:0], r[31:16], r[0] ^ r[17], "R1 random");
    end

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule